// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column addresses of one read or write burst on a synchronous DRAM. A load strobe captures a starting column, a length code, an order bit and the access direction. The block then presents one column per beat and moves to the next column on each advance strobe. Addresses stay inside an aligned block the size of the burst, in either sequential or XOR-interleaved order. A full-page mode counts through the whole row and wraps around until a terminate request stops it.

The block does not store the mode register and does not generate commands. It takes the decoded length and order as inputs. Its outputs are the column address, a flag that a burst is in progress and a flag that marks the final beat.

Top module: `burst_col_gen`

## Requirements
- R1: After reset `busy_o` and `final_o` are 0 and `col_o` is 0.
- R2: A `load_i` pulse captures `first_col_i`. From the next clock edge `col_o` equals that column and `busy_o` is 1. Length codes are 0→1, 1→2, 2→4, 3→8 and 7→full page. The codes 4, 5 and 6 give a length of 1.
- R3: In sequential order (`xor_order_i`=0) beat k presents the column whose low log2(L) bits are (first + k) mod L. The upper bits stay those of the first column.
- R4: In interleaved order (`xor_order_i`=1) beat k presents the first column with its low log2(L) bits XORed with k.
- R5: `final_o` is 1 while the last beat of a fixed-length burst is presented. An advance on that beat ends the burst: `busy_o` goes to 0 on the next edge.
- R6: In full-page mode each advance adds 1 to the column, wrapping from 255 to 0. `final_o` stays 0 and the burst runs until it is terminated.
- R7: A full-page burst loaded with `xor_order_i`=1 still runs in sequential order.
- R8: `stop_i` during a burst clears `busy_o` on the next edge. It wins over a simultaneous `adv_i`.
- R9: If `wr_i` and `single_wr_i` are both 1 at load, the burst has length 1 whatever the code. A read (`wr_i`=0) keeps the coded length.
- R10: `adv_i` and `stop_i` while idle are ignored and `col_o` holds.
- R11: `load_i` during a burst restarts it from the new column at beat 0. It wins over `stop_i` and `adv_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Start a new burst |
| first_col_i | input | 8 | Starting column |
| len_code_i | input | 3 | Burst length code |
| xor_order_i | input | 1 | 1 selects interleaved order |
| wr_i | input | 1 | 1 marks the burst as a write |
| single_wr_i | input | 1 | Forces writes to length 1 |
| adv_i | input | 1 | Advance to the next beat |
| stop_i | input | 1 | Terminate the burst |
| col_o | output | 8 | Current column address |
| busy_o | output | 1 | Burst in progress |
| final_o | output | 1 | Current beat is the last |

## Verification
Some rules are checked by assertions on every cycle:
- the upper column bits hold inside a fixed-length burst;
- a full-page burst steps by exactly one per advance;
- an advance on the final beat or a terminate ends the burst;
- an idle block holds its column.

The exact address sequences are shown only by the bench scenarios. These cover sequential and interleaved order at every length, the reserved codes, the single-write override, the full-page wrap, and restart in mid-burst.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
   localparam int unsigned LEN_W = 3;
   localparam logic [LEN_W-1:0] CODE_L1   = 3'd0;
   localparam logic [LEN_W-1:0] CODE_L2   = 3'd1;
   localparam logic [LEN_W-1:0] CODE_L4   = 3'd2;
   localparam logic [LEN_W-1:0] CODE_L8   = 3'd3;
   localparam logic [LEN_W-1:0] CODE_PAGE = 3'd7;

   typedef struct packed {
      logic page;
      logic xo;
   } burst_kind_t;
endpackage

// File: rtl/bcg_len_decode.sv
module bcg_len_decode
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic [LEN_W-1:0] code_i,
   input  logic             wr_i,
   input  logic             single_wr_i,
   output logic [COL_W-1:0] mask_o,
   output logic             page_o
);
   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   always_comb begin
      mask_o = '0;
      page_o = 1'b0;
      if (!(wr_i && single_wr_i)) begin
         unique case (code_i)
            CODE_L2:   mask_o = ONE;
            CODE_L4:   mask_o = COL_W'(3);
            CODE_L8:   mask_o = COL_W'(7);
            CODE_PAGE: begin
               mask_o = '1;
               page_o = 1'b1;
            end
            default:   mask_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/bcg_order.sv
module bcg_order #(
   parameter int unsigned COL_W      = 8,
   parameter bit          XOR_ENABLE = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             xo_i,
   output logic [COL_W-1:0] col_o
);
   logic [COL_W-1:0] sum;
   logic             xo_eff;

   assign sum = base_i + beat_i;

   generate
      if (XOR_ENABLE) begin : g_xor
         assign xo_eff = xo_i;
      end else begin : g_seq_only
         assign xo_eff = 1'b0;
      end
   endgenerate

   for (genvar b = 0; b < COL_W; b++) begin : g_bit
      always_comb begin
         if (!mask_i[b])
            col_o[b] = base_i[b];
         else if (xo_eff)
            col_o[b] = base_i[b] ^ beat_i[b];
         else
            col_o[b] = sum[b];
      end
   end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [COL_W-1:0] first_col_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             page_i,
   input  logic             xo_i,
   input  logic             adv_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] base_o,
   output logic [COL_W-1:0] beat_o,
   output logic [COL_W-1:0] mask_o,
   output burst_kind_t      kind_o,
   output logic             busy_o,
   output logic             final_o
);
   logic [COL_W-1:0] base_q, beat_q, mask_q;
   burst_kind_t      kind_q;
   logic             busy_q;

   assign final_o = busy_q && !kind_q.page && (beat_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         beat_q <= '0;
         mask_q <= '0;
         kind_q <= '0;
         busy_q <= 1'b0;
      end else if (load_i) begin
         base_q       <= first_col_i;
         beat_q       <= '0;
         mask_q       <= mask_i;
         kind_q.page  <= page_i;
         kind_q.xo    <= xo_i && !page_i;
         busy_q       <= 1'b1;
      end else if (busy_q && stop_i) begin
         busy_q <= 1'b0;
      end else if (busy_q && adv_i) begin
         if (final_o) busy_q <= 1'b0;
         else         beat_q <= beat_q + COL_W'(1);
      end
   end

   assign base_o = base_q;
   assign beat_o = beat_q;
   assign mask_o = mask_q;
   assign kind_o = kind_q;
   assign busy_o = busy_q;

   AST_FINAL_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      final_o && adv_i && !load_i && !stop_i |=> !busy_o); // R5
   AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && stop_i && !load_i |=> !busy_o); // R8
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
   import bcg_pkg::*;
#(
   parameter int unsigned COL_W      = 8,
   parameter bit          XOR_ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [COL_W-1:0] first_col_i,
   input  logic [LEN_W-1:0] len_code_i,
   input  logic             xor_order_i,
   input  logic             wr_i,
   input  logic             single_wr_i,
   input  logic             adv_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             busy_o,
   output logic             final_o
);
   if (COL_W < 3) begin : g_bad_width
      $error("COL_W must hold an 8-beat block");
   end

   logic [COL_W-1:0] dec_mask, base, beat, mask;
   logic             dec_page;
   burst_kind_t      kind;

   bcg_len_decode #(.COL_W(COL_W)) i_dec (
      .code_i      (len_code_i),
      .wr_i        (wr_i),
      .single_wr_i (single_wr_i),
      .mask_o      (dec_mask),
      .page_o      (dec_page)
   );

   bcg_ctrl #(.COL_W(COL_W)) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (load_i),
      .first_col_i (first_col_i),
      .mask_i      (dec_mask),
      .page_i      (dec_page),
      .xo_i        (xor_order_i),
      .adv_i       (adv_i),
      .stop_i      (stop_i),
      .base_o      (base),
      .beat_o      (beat),
      .mask_o      (mask),
      .kind_o      (kind),
      .busy_o      (busy_o),
      .final_o     (final_o)
   );

   bcg_order #(.COL_W(COL_W), .XOR_ENABLE(XOR_ENABLE)) i_order (
      .base_i (base),
      .beat_i (beat),
      .mask_i (mask),
      .xo_i   (kind.xo),
      .col_o  (col_o)
   );

   AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !kind.page && adv_i && !final_o && !load_i && !stop_i
      |=> ((col_o & ~mask) == ($past(col_o) & ~$past(mask)))); // R3
   AST_PAGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && kind.page && adv_i && !load_i && !stop_i
      |=> (col_o == $past(col_o) + COL_W'(1)) && !final_o); // R6
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o && !load_i |=> $stable(col_o)); // R10
endmodule

// File: tb/test_burst_col_gen.sv
module test_burst_col_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       load_i = 1'b0;
   logic [7:0] first_col_i = '0;
   logic [2:0] len_code_i = '0;
   logic       xor_order_i = 1'b0, wr_i = 1'b0, single_wr_i = 1'b0;
   logic       adv_i = 1'b0, stop_i = 1'b0;
   logic [7:0] col_o;
   logic       busy_o, final_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   burst_col_gen i_burst_col_gen (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .first_col_i(first_col_i),
      .len_code_i(len_code_i), .xor_order_i(xor_order_i), .wr_i(wr_i),
      .single_wr_i(single_wr_i), .adv_i(adv_i), .stop_i(stop_i),
      .col_o(col_o), .busy_o(busy_o), .final_o(final_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int blen(input int code, input bit wr, input bit sw);
      if (wr && sw) return 1;
      case (code)
         1: return 2;
         2: return 4;
         3: return 8;
         default: return 1;
      endcase
   endfunction

   function automatic int exp_col(input int s, input int k, input int l, input bit xo);
      int base = s - (s % l);
      if (xo) return base + ((s % l) ^ k);
      return base + ((s + k) % l);
   endfunction

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_load(input int s, input int code, input bit xo, input bit wr, input bit sw);
      first_col_i = 8'(s); len_code_i = 3'(code); xor_order_i = xo;
      wr_i = wr; single_wr_i = sw; load_i = 1'b1;
      step();
      load_i = 1'b0;
   endtask

   // R2 R3 R4 R5 R9: full fixed-length burst
   task automatic t_burst(input int s, input int code, input bit xo, input bit wr,
                          input bit sw, input string req);
      int l = blen(code, wr, sw);
      do_load(s, code, xo, wr, sw);
      check(busy_o == 1'b1, "R2 busy after load", int'(busy_o), 1);
      for (int k = 0; k < l; k++) begin
         check(col_o == 8'(exp_col(s, k, l, xo)), req, int'(col_o), exp_col(s, k, l, xo));
         check(final_o == (k == l - 1), "R5 final flag", int'(final_o), int'(k == l - 1));
         adv_i = 1'b1;
         step();
         adv_i = 1'b0;
      end
      check(busy_o == 1'b0, "R5 burst ended", int'(busy_o), 0);
   endtask

   task automatic t_reset();
      check(busy_o == 1'b0, "R1 busy", int'(busy_o), 0);
      check(final_o == 1'b0, "R1 final", int'(final_o), 0);
      check(col_o == 8'd0, "R1 col", int'(col_o), 0);
   endtask

   // R6 R7 R8: full page wrap and terminate
   task automatic t_page(input int s, input bit xo);
      do_load(s, 7, xo, 1'b0, 1'b0);
      for (int k = 0; k < 12; k++) begin
         check(col_o == 8'((s + k) % 256), xo ? "R7 page order" : "R6 page wrap",
               int'(col_o), (s + k) % 256);
         check(final_o == 1'b0, "R6 no final", int'(final_o), 0);
         adv_i = 1'b1;
         step();
      end
      stop_i = 1'b1;
      step();
      adv_i = 1'b0; stop_i = 1'b0;
      check(busy_o == 1'b0, "R8 stop ends page", int'(busy_o), 0);
      check(col_o == 8'((s + 12) % 256), "R8 stop beats adv", int'(col_o), (s + 12) % 256);
   endtask

   // R10: idle strobes ignored
   task automatic t_idle();
      logic [7:0] held = col_o;
      adv_i = 1'b1; stop_i = 1'b1;
      step(); step();
      adv_i = 1'b0; stop_i = 1'b0;
      check(col_o == held, "R10 col held", int'(col_o), int'(held));
      check(busy_o == 1'b0, "R10 stays idle", int'(busy_o), 0);
   endtask

   // R11: restart in mid-burst
   task automatic t_restart();
      do_load(8'h40, 3, 1'b0, 1'b0, 1'b0);
      adv_i = 1'b1; step(); step(); adv_i = 1'b0;
      check(col_o == 8'h42, "R11 before restart", int'(col_o), 8'h42);
      adv_i = 1'b1; stop_i = 1'b1;
      do_load(8'h95, 2, 1'b0, 1'b0, 1'b0);
      adv_i = 1'b0; stop_i = 1'b0;
      check(col_o == 8'h95, "R11 restart col", int'(col_o), 8'h95);
      check(busy_o == 1'b1, "R11 restart busy", int'(busy_o), 1);
      adv_i = 1'b1; step(); adv_i = 1'b0;
      check(col_o == 8'h96, "R11 restart beat1", int'(col_o), 8'h96);
      stop_i = 1'b1; step(); stop_i = 1'b0;
      check(busy_o == 1'b0, "R8 stop fixed burst", int'(busy_o), 0);
   endtask

   initial begin
      step(); step();
      t_reset();
      rst_n = 1'b1;
      step();
      t_reset();
      t_idle();
      t_burst(8'h13, 0, 1'b0, 1'b0, 1'b0, "R2 length 1");
      t_burst(8'h13, 1, 1'b0, 1'b0, 1'b0, "R3 seq L2");
      t_burst(8'h2E, 2, 1'b0, 1'b0, 1'b0, "R3 seq L4");
      t_burst(8'hA5, 3, 1'b0, 1'b0, 1'b0, "R3 seq L8");
      t_burst(8'hFE, 3, 1'b0, 1'b0, 1'b0, "R3 seq L8 top");
      t_burst(8'h13, 1, 1'b1, 1'b0, 1'b0, "R4 xor L2");
      t_burst(8'h2E, 2, 1'b1, 1'b0, 1'b0, "R4 xor L4");
      t_burst(8'hA5, 3, 1'b1, 1'b0, 1'b0, "R4 xor L8");
      t_burst(8'h66, 4, 1'b0, 1'b0, 1'b0, "R2 reserved 4");
      t_burst(8'h67, 5, 1'b1, 1'b0, 1'b0, "R2 reserved 5");
      t_burst(8'h68, 6, 1'b0, 1'b0, 1'b0, "R2 reserved 6");
      t_burst(8'h3B, 3, 1'b0, 1'b1, 1'b1, "R9 single write");
      t_burst(8'h3B, 3, 1'b0, 1'b0, 1'b1, "R9 read keeps length");
      t_burst(8'h3B, 2, 1'b1, 1'b1, 1'b0, "R9 write no override");
      t_page(250, 1'b0);
      t_page(3, 1'b1);
      t_idle();
      t_restart();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog", 0, 1);
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule